// File: doc/BRIEF.md
# Ring-Expanded Deep FIFO

This block builds one deep first-in, first-out queue out of several identical storage slices. Each slice holds a fixed number of words and has its own write pointer, read pointer and occupancy count. The slices are linked in a ring. A write token and a read token travel around it. The slice that holds the write token takes every accepted write. The slice that holds the read token presents the oldest word and takes every accepted read. When a slice writes its last physical location, it hands the write token to the next slice. When it reads its last physical location, it hands the read token on in the same way. The last slice hands back to the first.

Writers and readers share one strobe each and one data bus each. The output is show-ahead: `rd_data` always carries the oldest unread word while `empty` is low. A one-hot multiplexer steered by the read token picks that word. The composite flags combine the per-slice flags, but only the slice that owns the relevant token can raise one. `full` is therefore high only when the whole ring holds `SLICES*SLICE_DEPTH` words, and `empty` is high only when it holds none. Each slice runs a four-state token machine. The states are TOK_NONE, TOK_WR, TOK_RD and TOK_BOTH, and its two transitions are PASS_OUT (give a token away) and PASS_IN (receive one). A strap selects the reset state: the first slice starts in TOK_BOTH and every other slice starts in TOK_NONE.

Top module: `dxf_ring_fifo`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `empty` is 1 and `full` is 0.
- R2: Whenever `empty` is 0, `rd_data` shows the oldest unread word. A read removes that word, so the words come out in the order they were written, across all slice boundaries.
- R3: `full` is 1 exactly when `SLICES*SLICE_DEPTH` words are held, and `full` and `empty` are never 1 together.
- R4: A write strobe while `full` is 1 (and no read in that cycle) is ignored. The stored contents are unchanged and `full` stays 1.
- R5: A read strobe while `empty` is 1 (and no write in that cycle) is ignored. `empty` stays 1 and later data comes out intact.
- R6: At every moment exactly one slice holds the write token and exactly one holds the read token. After reset both are in the first slice. A token moves to the next slice (the last slice wraps to the first) at the clock edge on which its holder writes or reads its last location.
- R7: A write and a read in the same cycle both take effect. This holds even when the write-token hand-off and the read-token hand-off happen on the same edge.
- R8: With `full` at 1, a simultaneous write and read performs only the read. With `empty` at 1, a simultaneous write and read performs only the write.
- R9: The flags settle right after the edge that changes the count. `full` falls after an accepted read from a full ring, and `empty` falls after an accepted write into an empty ring.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, shared by all slices |
| wr_data | input | DATA_W | Word to write |
| rd_en | input | 1 | Read strobe, shared by all slices |
| rd_data | output | DATA_W | Oldest unread word (show-ahead) |
| full | output | 1 | Composite full flag |
| empty | output | 1 | Composite empty flag |

## Verification
Two token hand-offs can land on the same clock edge. One is the write token leaving one slice after its last location is written. The other is the read token leaving a different slice after its last location is read. The bench provokes this by writing seven words into the default three-slice, four-word ring and reading three, then issuing a write and a read together. That write lands in the second slice's last location and that read empties the first slice's last location. The result is judged by draining the ring against a reference queue and checking every word and every flag. A long stream of simultaneous reads and writes at a fixed level also moves both tokens many times in overlapping cycles, and the same-cycle cases at the full and empty boundaries are checked on their own.

// File: rtl/dxf_pkg.sv
package dxf_pkg;

    // Token ownership of one slice: bit 0 = write token, bit 1 = read token.
    typedef enum logic [1:0] {
        TOK_NONE = 2'b00,
        TOK_WR   = 2'b01,
        TOK_RD   = 2'b10,
        TOK_BOTH = 2'b11
    } tok_state_t;

    // Hand-off signal between neighbouring slices, one wire per token kind.
    typedef struct packed {
        logic wr_pass;
        logic rd_pass;
    } xfer_t;

endpackage

// File: rtl/dxf_slice_store.sv
module dxf_slice_store #(
    parameter int DATA_W = 9,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic              rd_go,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] head,
    output logic              wr_at_last,
    output logic              rd_at_last,
    output logic              is_full,
    output logic              is_empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic [CW-1:0]     cnt;

    always_ff @(posedge clk) begin
        if (wr_go) mem[wptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (wr_go) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (rd_go) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            unique case ({wr_go, rd_go})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign head       = mem[rptr];
    assign wr_at_last = (wptr == LAST);
    assign rd_at_last = (rptr == LAST);
    assign is_full    = (cnt == CW'(DEPTH));
    assign is_empty   = (cnt == '0);

endmodule

// File: rtl/dxf_token_fsm.sv
module dxf_token_fsm
    import dxf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  first_load,
    input  xfer_t xi,
    input  xfer_t xo,
    output logic  has_wr,
    output logic  has_rd
);
    tok_state_t state, nxt;

    // State register; the strap picks the reset state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= first_load ? TOK_BOTH : TOK_NONE;
        else        state <= nxt;
    end

    // Transitions: PASS_OUT drops a held token, PASS_IN gains one.
    always_comb begin
        nxt = state;
        unique case (state)
            TOK_NONE: nxt = tok_state_t'({xi.rd_pass, xi.wr_pass});
            TOK_WR:   nxt = tok_state_t'({xi.rd_pass,
                                          (~xo.wr_pass | xi.wr_pass)});
            TOK_RD:   nxt = tok_state_t'({(~xo.rd_pass | xi.rd_pass),
                                          xi.wr_pass});
            TOK_BOTH: nxt = tok_state_t'({(~xo.rd_pass | xi.rd_pass),
                                          (~xo.wr_pass | xi.wr_pass)});
            default:  nxt = TOK_NONE;
        endcase
    end

    // Outputs decoded from the state.
    always_comb begin
        has_wr = 1'b0;
        has_rd = 1'b0;
        unique case (state)
            TOK_NONE: begin has_wr = 1'b0; has_rd = 1'b0; end
            TOK_WR:   begin has_wr = 1'b1; has_rd = 1'b0; end
            TOK_RD:   begin has_wr = 1'b0; has_rd = 1'b1; end
            TOK_BOTH: begin has_wr = 1'b1; has_rd = 1'b1; end
            default:  begin has_wr = 1'b0; has_rd = 1'b0; end
        endcase
    end

endmodule

// File: rtl/dxf_out_mux.sv
module dxf_out_mux #(
    parameter int DATA_W = 9,
    parameter int WAYS   = 3
) (
    input  logic [WAYS-1:0]             sel,
    input  logic [WAYS-1:0][DATA_W-1:0] ways,
    output logic [DATA_W-1:0]           y
);
    always_comb begin
        y = '0;
        for (int i = 0; i < WAYS; i++) begin
            y = y | (ways[i] & {DATA_W{sel[i]}});
        end
    end
endmodule

// File: rtl/dxf_ring_fifo.sv
module dxf_ring_fifo
    import dxf_pkg::*;
#(
    parameter int DATA_W      = 9,
    parameter int SLICE_DEPTH = 4,
    parameter int SLICES      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              full,
    output logic              empty
);
    logic [SLICES-1:0]             wtok, rtok;
    logic [SLICES-1:0]             wr_go, rd_go;
    logic [SLICES-1:0]             w_last, r_last;
    logic [SLICES-1:0]             s_full, s_empty;
    logic [SLICES-1:0][DATA_W-1:0] heads;
    xfer_t                         xo [SLICES];

    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        localparam int PREV = (s + SLICES - 1) % SLICES;

        assign wr_go[s]      = wr_en & wtok[s] & ~s_full[s];
        assign rd_go[s]      = rd_en & rtok[s] & ~s_empty[s];
        assign xo[s].wr_pass = wr_go[s] & w_last[s];
        assign xo[s].rd_pass = rd_go[s] & r_last[s];

        dxf_slice_store #(
            .DATA_W (DATA_W),
            .DEPTH  (SLICE_DEPTH)
        ) u_store (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_go      (wr_go[s]),
            .rd_go      (rd_go[s]),
            .din        (wr_data),
            .head       (heads[s]),
            .wr_at_last (w_last[s]),
            .rd_at_last (r_last[s]),
            .is_full    (s_full[s]),
            .is_empty   (s_empty[s])
        );

        dxf_token_fsm u_tok (
            .clk        (clk),
            .rst_n      (rst_n),
            .first_load ((s == 0) ? 1'b1 : 1'b0),
            .xi         (xo[PREV]),
            .xo         (xo[s]),
            .has_wr     (wtok[s]),
            .has_rd     (rtok[s])
        );
    end

    dxf_out_mux #(
        .DATA_W (DATA_W),
        .WAYS   (SLICES)
    ) u_mux (
        .sel  (rtok),
        .ways (heads),
        .y    (rd_data)
    );

    assign full  = |(wtok & s_full);
    assign empty = |(rtok & s_empty);

endmodule

// File: rtl/dxf_ring_chk.sv
module dxf_ring_chk #(
    parameter int SLICES = 3,
    parameter int CAP    = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic              full,
    input logic              empty,
    input logic [SLICES-1:0] wtok,
    input logic [SLICES-1:0] rtok
);
    localparam int OW = $clog2(CAP + 1);
    logic [OW-1:0] occ;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) occ <= '0;
        else occ <= occ + OW'(wr_en && !full) - OW'(rd_en && !empty);
    end

    a_r3_full_at_cap: assert property (@(posedge clk) disable iff (!rst_n)
        full == (occ == OW'(CAP)));
    a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
    a_r4_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        full && wr_en && !rd_en |=> full);
    a_r5_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
        empty && rd_en && !wr_en |=> empty);
    a_r6_one_wr_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wtok) == 1);
    a_r6_one_rd_owner: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rtok) == 1);
    a_r9_full_clears: assert property (@(posedge clk) disable iff (!rst_n)
        full && rd_en |=> !full);
    a_r9_empty_clears: assert property (@(posedge clk) disable iff (!rst_n)
        empty && wr_en |=> !empty);

endmodule

bind dxf_ring_fifo dxf_ring_chk #(
    .SLICES (SLICES),
    .CAP    (SLICES * SLICE_DEPTH)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .full  (full),
    .empty (empty),
    .wtok  (wtok),
    .rtok  (rtok)
);

// File: tb/sim_dxf_ring_fifo.sv
`timescale 1ns/1ps
module sim_dxf_ring_fifo;
    localparam int DW  = 9;
    localparam int SD  = 4;
    localparam int NS  = 3;
    localparam int CAP = SD * NS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic          full, empty;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [DW-1:0] q[$];
    logic [DW-1:0] seed = 9'h1A5;

    always #2 clk = ~clk;

    dxf_ring_fifo #(.DATA_W(DW), .SLICE_DEPTH(SD), .SLICES(NS)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .full(full), .empty(empty));

    task automatic check(input string tag, input string what,
                         input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic flags(input string tag);
        check(tag, "full", int'(full), int'(q.size() == CAP));
        check(tag, "empty", int'(empty), int'(q.size() == 0));
    endtask

    // One clock of stimulus against the reference queue.
    task automatic cyc(input bit we, input logic [DW-1:0] wd, input bit re,
                       input string tag);
        bit acc_w, acc_r;
        @(negedge clk);
        wr_en = we; wr_data = wd; rd_en = re;
        #1;
        if (q.size() > 0) check(tag, "rd_data head", int'(rd_data), int'(q[0]));
        acc_w = we && (q.size() < CAP);
        acc_r = re && (q.size() > 0);
        @(posedge clk);
        #1;
        if (acc_r) void'(q.pop_front());
        if (acc_w) q.push_back(wd);
        wr_en = 1'b0; rd_en = 1'b0;
        flags(tag);
    endtask

    function automatic logic [DW-1:0] nextval();
        seed = {seed[7:0], seed[8] ^ seed[4]};
        return seed;
    endfunction

    task automatic drain(input string tag);
        while (q.size() > 0) cyc(1'b0, '0, 1'b1, tag);
    endtask

    // R1: flags out of reset
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 flags("R1");
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk);
        #1 flags("R1");
    endtask

    // R2 and R6: order kept across slice boundaries, tokens wrap twice
    task automatic t_order();
        for (int k = 0; k < 10; k++) cyc(1'b1, nextval(), 1'b0, "R2");
        drain("R2");
        for (int k = 0; k < 2 * CAP + 3; k++) begin
            cyc(1'b1, nextval(), 1'b0, "R6");
            cyc(1'b0, '0, 1'b1, "R6");
        end
    endtask

    // R3 and R4: fill to capacity, write while full ignored
    task automatic t_fill();
        for (int k = 0; k < CAP - 1; k++) cyc(1'b1, nextval(), 1'b0, "R3");
        check("R3", "full one short", int'(full), 0);
        cyc(1'b1, nextval(), 1'b0, "R3");
        check("R3", "full at cap", int'(full), 1);
        cyc(1'b1, 9'h1FF, 1'b0, "R4");
        cyc(1'b1, 9'h000, 1'b0, "R4");
        check("R4", "full kept", int'(full), 1);
        drain("R4");
    endtask

    // R5: read while empty ignored
    task automatic t_empty_read();
        cyc(1'b0, '0, 1'b1, "R5");
        cyc(1'b0, '0, 1'b1, "R5");
        check("R5", "empty kept", int'(empty), 1);
        cyc(1'b1, 9'h0C3, 1'b0, "R5");
        check("R5", "head after write", int'(rd_data), 9'h0C3);
        drain("R5");
    endtask

    // R7: both token hand-offs on one edge, then streaming
    task automatic t_coincide();
        for (int k = 0; k < 7; k++) cyc(1'b1, nextval(), 1'b0, "R7");
        for (int k = 0; k < 3; k++) cyc(1'b0, '0, 1'b1, "R7");
        cyc(1'b1, nextval(), 1'b1, "R7");
        check("R7", "level kept", q.size(), 4);
        for (int k = 0; k < 40; k++) cyc(1'b1, nextval(), 1'b1, "R7");
        drain("R7");
    endtask

    // R8 and R9: same-cycle at the boundaries, flag timing
    task automatic t_edges();
        cyc(1'b1, 9'h055, 1'b1, "R8");
        check("R8", "write at empty taken", int'(empty), 0);
        check("R9", "empty fell after write", int'(empty), 0);
        for (int k = 0; k < CAP - 1; k++) cyc(1'b1, nextval(), 1'b0, "R8");
        cyc(1'b1, 9'h1EE, 1'b1, "R8");
        check("R8", "write at full refused", int'(full), 0);
        check("R9", "full fell after read", q.size(), CAP - 1);
        drain("R8");
    endtask

    initial begin
        t_reset();
        t_order();
        t_fill();
        t_empty_read();
        t_coincide();
        t_edges();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule